// File: doc/BRIEF.md
# SD Card Clock Divider

This block derives the card clock of an SD/MMC host from the host's master clock. Software works out a request quotient, the master frequency over the wanted card frequency rounded up, and presents it on `req_ratio_i` together with a double-data-rate flag and a power-on flag. From these the block picks a divider field. A field of zero passes the master clock straight through. Any other value N produces a square wave whose period is 2·N master cycles.

The field is recomputed on every master edge. The running clock generator takes up a new field only at its next output edge, so a change never shortens a half period. A stop input holds the card clock low while the card is unpowered. The block also reports the effective divide ratio and registers the bus-width, bus-speed and DDR bits next to the divider field.

Top module: `card_clk_divider`

## Requirements
- R1: With a non-zero active divider N, the card clock is high for exactly N master cycles and low for exactly N master cycles, so its period is 2·N.
- R2: With an active divider of zero (bypass), the card clock follows the master clock level.
- R3: The field becomes 0 only when `req_ratio_i` equals 1 (request at or above the master frequency) and `ddr_i` is low. `req_ratio_i` = 0 means a zero-frequency request.
- R4: While `ddr_i` is high the field is never 0. A request quotient of 1 in DDR mode gives a field of 1.
- R5: For `req_ratio_i` ≥ 2, or 1 with DDR, the field is ceil(`req_ratio_i`/2), clamped to the largest field value (1023 for the 10-bit default).
- R6: A request quotient of 0 sets the field to its largest value and does not stop the clock.
- R7: A field change reaches the generator only at its next output toggle, or at once when the generator is in bypass. The first phase after the change lasts the new value.
- R8: `div_ratio_o` reads 2·field, or 1 in bypass, while `pwr_on_i` is high. It reads 0 while `pwr_on_i` is low.
- R9: While `clk_stop_i` is high the card clock is low. After release it starts with a low phase of the full field length.
- R10: `bus_width_o`, `fast_bus_o` and `ddr_o` carry the values of their inputs from the previous master edge.
- R11: After synchronous reset the field is at its maximum, the card clock is low, and `div_ratio_o` and the flag outputs are 0.
- Latency: the field, `div_ratio_o` and the flags change at the first master edge after their inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| req_ratio_i | input | RATIO_W | ceil(master/requested frequency); 0 = zero request |
| ddr_i | input | 1 | Double-data-rate timing selected |
| pwr_on_i | input | 1 | Card power state is on |
| clk_stop_i | input | 1 | Hold card clock low |
| bus_width_i | input | 2 | Bus width code, passed through |
| fast_bus_i | input | 1 | Bus speed bit, passed through |
| card_clk_o | output | 1 | Card clock |
| div_field_o | output | DIV_W | Registered divider field |
| div_ratio_o | output | DIV_W+1 | Effective master/card ratio, 0 when not powered on |
| bus_width_o | output | 2 | Registered bus width code |
| fast_bus_o | output | 1 | Registered bus speed bit |
| ddr_o | output | 1 | Registered DDR bit |

## Verification
The critical overlap is a field update landing on the same master edge as an output toggle of the generator. The new value must then govern the phase that is just starting, not the one that is ending. The bench changes the request while a long phase is half finished, right before a toggle, and again while the stop input is high. It compares the card clock against a cycle-level reference model in both halves of every master cycle, which catches any phase that comes out too short or too long.

// File: rtl/card_clk_pkg.sv
// Shared types for the card clock divider.
// Assumes nothing beyond a 2-bit bus width code.
package card_clk_pkg;
    typedef struct packed {
        logic [1:0] width;
        logic       fast;
        logic       ddr;
    } bus_cfg_t;
endpackage

// File: rtl/card_div_calc.sv
// Maps a request quotient to a divider field: 0 = bypass, otherwise
// ceil(quotient/2) clamped to the field maximum. Purely combinational.
// Assumes the quotient is already ceil(master/requested) or 0 for "no clock".
module card_div_calc #(
    parameter int RATIO_W = 16,
    parameter int DIV_W   = 10
) (
    input  logic [RATIO_W-1:0] ratio_i,
    input  logic               ddr_i,
    output logic [DIV_W-1:0]   field_o
);
    localparam logic [DIV_W-1:0]   DIV_MAX  = {DIV_W{1'b1}};
    localparam logic [RATIO_W:0]   DIV_MAXW = (RATIO_W+1)'(DIV_MAX);

    logic [RATIO_W:0] half_up;

    // Rounded-up half of the quotient, one extra bit against overflow
    always_comb half_up = ({1'b0, ratio_i} + (RATIO_W+1)'(1)) >> 1;

    // Select bypass, saturation or the rounded half
    always_comb begin
        if (ratio_i == '0)
            field_o = DIV_MAX;
        else if (ratio_i == RATIO_W'(1) && !ddr_i)
            field_o = '0;
        else if (half_up > DIV_MAXW)
            field_o = DIV_MAX;
        else
            field_o = half_up[DIV_W-1:0];
    end
endmodule

// File: rtl/card_clk_gen.sv
// Generates the card clock from the active divider; loads a new field
// only on its own output toggle (or at once while bypassing).
// Assumes field_i is a registered, glitch-free value.
module card_clk_gen #(
    parameter int DIV_W = 10
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             stop_i,
    input  logic [DIV_W-1:0] field_i,
    output logic             card_clk_o
);
    localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

    logic [DIV_W-1:0] act_q;
    logic [DIV_W-1:0] cnt_q;
    logic             dclk_q;
    logic             bypass;
    logic             wrap;

    always_comb bypass = (act_q == '0);
    always_comb wrap   = (cnt_q == act_q - DIV_W'(1));

    // Half-period counter, divided output and active-divider update
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_q  <= DIV_MAX;
            cnt_q  <= '0;
            dclk_q <= 1'b0;
        end else if (stop_i) begin
            act_q  <= field_i;
            cnt_q  <= '0;
            dclk_q <= 1'b0;
        end else if (bypass) begin
            act_q  <= field_i;
            cnt_q  <= '0;
            dclk_q <= 1'b0;
        end else if (wrap) begin
            act_q  <= field_i;
            cnt_q  <= '0;
            dclk_q <= ~dclk_q;
        end else begin
            cnt_q  <= cnt_q + DIV_W'(1);
        end
    end

    // Output select: held low, master clock in bypass, else divided
    always_comb begin
        if (stop_i)
            card_clk_o = 1'b0;
        else if (bypass)
            card_clk_o = clk_i;
        else
            card_clk_o = dclk_q;
    end
endmodule

// File: rtl/card_clk_divider.sv
// Top: registers the divider field, reported ratio and bus bits, and
// drives the card clock generator. Synchronous active-low reset.
// Assumes all inputs are synchronous to clk_i.
module card_clk_divider #(
    parameter int RATIO_W = 16,
    parameter int DIV_W   = 10
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [RATIO_W-1:0] req_ratio_i,
    input  logic               ddr_i,
    input  logic               pwr_on_i,
    input  logic               clk_stop_i,
    input  logic [1:0]         bus_width_i,
    input  logic               fast_bus_i,
    output logic               card_clk_o,
    output logic [DIV_W-1:0]   div_field_o,
    output logic [DIV_W:0]     div_ratio_o,
    output logic [1:0]         bus_width_o,
    output logic               fast_bus_o,
    output logic               ddr_o
);
    import card_clk_pkg::*;

    localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};

    logic [DIV_W-1:0] field_d;
    logic [DIV_W-1:0] field_q;
    logic [DIV_W:0]   ratio_d;
    logic [DIV_W:0]   ratio_q;
    bus_cfg_t         cfg_q;

    card_div_calc #(.RATIO_W(RATIO_W), .DIV_W(DIV_W)) u_calc (
        .ratio_i (req_ratio_i),
        .ddr_i   (ddr_i),
        .field_o (field_d)
    );

    // Effective ratio of the new field, zeroed outside power-on
    always_comb begin
        if (!pwr_on_i)
            ratio_d = '0;
        else if (field_d == '0)
            ratio_d = (DIV_W+1)'(1);
        else
            ratio_d = {field_d, 1'b0};
    end

    // Configuration register: field, reported ratio, bus bits
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            field_q <= DIV_MAX;
            ratio_q <= '0;
            cfg_q   <= '0;
        end else begin
            field_q <= field_d;
            ratio_q <= ratio_d;
            cfg_q   <= '{width: bus_width_i, fast: fast_bus_i, ddr: ddr_i};
        end
    end

    card_clk_gen #(.DIV_W(DIV_W)) u_gen (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .stop_i     (clk_stop_i),
        .field_i    (field_q),
        .card_clk_o (card_clk_o)
    );

    assign div_field_o = field_q;
    assign div_ratio_o = ratio_q;
    assign bus_width_o = cfg_q.width;
    assign fast_bus_o  = cfg_q.fast;
    assign ddr_o       = cfg_q.ddr;
endmodule

// File: rtl/card_clk_divider_chk.sv
// Property checker for card_clk_divider, attached by bind below.
module card_clk_divider_chk #(
    parameter int RATIO_W = 16,
    parameter int DIV_W   = 10
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [RATIO_W-1:0] req_ratio_i,
    input logic               ddr_i,
    input logic               pwr_on_i,
    input logic [1:0]         bus_width_i,
    input logic [DIV_W-1:0]   div_field_o,
    input logic [DIV_W:0]     div_ratio_o,
    input logic [1:0]         bus_width_o
);
    localparam logic [DIV_W-1:0] DIV_MAX = {DIV_W{1'b1}};
    localparam int               SAT_AT  = 2 * ((1 << DIV_W) - 1);

    // R6
    zero_req_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ratio_i == '0) |=> (div_field_o == DIV_MAX));

    // R4
    ddr_no_bypass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ddr_i |=> (div_field_o != '0));

    // R5
    saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int'(req_ratio_i) > SAT_AT) |=> (div_field_o == DIV_MAX));

    // R8
    ratio_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pwr_on_i |=> (div_ratio_o == '0));

    // R10
    width_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (bus_width_o == $past(bus_width_i)));
endmodule

bind card_clk_divider card_clk_divider_chk #(.RATIO_W(RATIO_W), .DIV_W(DIV_W)) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_ratio_i (req_ratio_i),
    .ddr_i       (ddr_i),
    .pwr_on_i    (pwr_on_i),
    .bus_width_i (bus_width_i),
    .div_field_o (div_field_o),
    .div_ratio_o (div_ratio_o),
    .bus_width_o (bus_width_o)
);

// File: tb/tb_card_clk_divider.sv
`timescale 1ns/1ps
module tb_card_clk_divider;
    localparam int RATIO_W = 16;
    localparam int DIV_W   = 10;
    localparam int DMAX    = (1 << DIV_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [RATIO_W-1:0] ratio = '0;
    logic               ddr = 1'b0;
    logic               pwr = 1'b0;
    logic               stop = 1'b0;
    logic [1:0]         bw = '0;
    logic               fast = 1'b0;
    logic               card_clk;
    logic [DIV_W-1:0]   field;
    logic [DIV_W:0]     dratio;
    logic [1:0]         bw_o;
    logic               fast_o;
    logic               ddr_o;

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    bit armed   = 0;
    bit done    = 0;

    // behavioural reference state
    int m_field, m_act, m_cnt, m_clk, m_ratio, m_bw, m_fast, m_ddr;
    bit m_rst;

    always #2 clk = ~clk;

    card_clk_divider #(.RATIO_W(RATIO_W), .DIV_W(DIV_W)) dut (
        .clk_i(clk), .rst_ni(rst_n), .req_ratio_i(ratio), .ddr_i(ddr),
        .pwr_on_i(pwr), .clk_stop_i(stop), .bus_width_i(bw), .fast_bus_i(fast),
        .card_clk_o(card_clk), .div_field_o(field), .div_ratio_o(dratio),
        .bus_width_o(bw_o), .fast_bus_o(fast_o), .ddr_o(ddr_o)
    );

    function automatic int want_field(int r, bit d);
        int h;
        if (r == 0) return DMAX;
        if (r == 1 && !d) return 0;
        h = (r + 1) / 2;
        return (h > DMAX) ? DMAX : h;
    endfunction

    task automatic cmp(string tag, int act, int exp, inout bit bad);
        if (act != exp) begin
            bad = 1;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, act, exp);
        end
    endtask

    // reference update on each master edge, then two samples per cycle
    always @(posedge clk) begin
        bit bad;
        int nf;
        cyc++;
        if (!rst_n) begin
            m_rst = 1; m_field = DMAX; m_act = DMAX; m_cnt = 0; m_clk = 0;
            m_ratio = 0; m_bw = 0; m_fast = 0; m_ddr = 0;
        end else begin
            m_rst = 0;
            nf = want_field(int'(ratio), ddr);
            if (stop) begin m_clk = 0; m_cnt = 0; m_act = m_field; end
            else if (m_act == 0) begin m_clk = 0; m_cnt = 0; m_act = m_field; end
            else if (m_cnt + 1 == m_act) begin m_clk = 1 - m_clk; m_cnt = 0; m_act = m_field; end
            else m_cnt++;
            m_field = nf;
            m_ratio = !pwr ? 0 : (nf == 0 ? 1 : 2 * nf);
            m_bw = bw; m_fast = fast; m_ddr = ddr;
        end
        armed = 1;
        #1;
        bad = 0;
        vectors++;
        cmp(m_rst ? "R11 field" : (m_field == DMAX ? "R6 field" : "R5 field"), field, m_field, bad);
        cmp(m_rst ? "R11 ratio" : "R8 ratio", dratio, m_ratio, bad);
        cmp(m_rst ? "R11 flags" : "R10 flags", {bw_o, fast_o, ddr_o},
            m_bw * 4 + m_fast * 2 + m_ddr, bad);
        cmp(stop ? "R9 clk-high" : (m_act == 0 ? "R2 clk-high" : "R7 clk-high"), card_clk,
            stop ? 0 : (m_act == 0 ? 1 : m_clk), bad);
        #2;
        vectors++;
        cmp(stop ? "R9 clk-low" : (m_act == 0 ? "R2 clk-low" : "R7 clk-low"), card_clk,
            stop ? 0 : (m_act == 0 ? 0 : m_clk), bad);
        if (bad) fails++;
    end

    // watchdog
    always @(posedge clk) begin
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    // measure high and low phase lengths of the card clock (R1)
    task automatic measure(string tag, int half);
        int hi = 0, lo = 0;
        bit prev;
        @(posedge clk); #3; prev = card_clk;
        forever begin
            @(posedge clk); #3;
            if (!prev && card_clk) break;
            prev = card_clk;
        end
        while (card_clk) begin hi++; @(posedge clk); #3; end
        while (!card_clk) begin lo++; @(posedge clk); #3; end
        vectors++;
        if (hi != half || lo != half) begin
            fails++;
            $display("FAIL %s: actual high %0d low %0d expected %0d each", tag, hi, lo, half);
        end
    endtask

    initial begin
        step(3);
        rst_n = 1; pwr = 1;
        // R5 R1: quotient 8 -> field 4, period 8
        ratio = 8; bw = 2'd1; fast = 1; step(12);
        measure("R1 div4", 4);
        // R5: odd quotient 7 rounds up to 4; then 3 -> 2
        @(negedge clk); ratio = 7; step(10);
        @(negedge clk); ratio = 3; bw = 2'd2; step(10);
        measure("R1 div2", 2);
        // R3 R2: quotient 1 without DDR -> bypass
        @(negedge clk); ratio = 1; fast = 0; step(20);
        // R4: same quotient in DDR mode -> field 1
        @(negedge clk); ddr = 1; step(8);
        measure("R1 R4 div1", 1);
        // R6: zero request -> largest field, clock keeps running
        @(negedge clk); ratio = 0; ddr = 0; step(2200);
        // R7: change mid-phase, takes effect at next toggle
        @(negedge clk); ratio = 4; step(1100);
        measure("R1 R7 div2 after change", 2);
        // R7: change landing on a toggle edge
        @(negedge clk); ratio = 10; step(1);
        @(negedge clk); ratio = 6; step(30);
        // R5: saturation
        @(negedge clk); ratio = 16'd60000; step(2100);
        @(negedge clk); ratio = 16'hFFFF; step(10);
        // R8: power off zeroes reported ratio
        @(negedge clk); pwr = 0; ratio = 12; step(30);
        // R9: stop holds clock low, also with a change during stop
        @(negedge clk); stop = 1; step(5);
        @(negedge clk); ratio = 2; step(5);
        @(negedge clk); stop = 0; step(12);
        measure("R1 R9 after stop", 1);
        // R9 with bypass request during stop
        @(negedge clk); stop = 1; ratio = 1; pwr = 1; step(6);
        @(negedge clk); stop = 0; step(10);
        // R11: reset mid-run
        @(negedge clk); rst_n = 0; ratio = 5; step(3);
        @(negedge clk); rst_n = 1; step(30);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule